// File: doc/BRIEF.md
# Host Bus Access Sequencer

This block connects a host microprocessor bus to a chip's internal shared memory and command register. The bus strobes are asynchronous. The block samples the active-low chip-select, read and write strobes on the system clock. Once an access is qualified, it decodes the top address bit to pick either the command register or RAM. It then runs the external buffers through a fixed cycle sequence:

1. The address-buffer enable pulses for one cycle.
2. The data-latch clock is held low for three cycles.
3. A one-cycle memory strobe marks the data phase.
4. The data-latch clock rises again, together with the acknowledge.

The data-buffer enable and the direction output cover the whole access.

Two things can defer an access. The first is a holdoff window that opens after every completed host access. The second is a grant-style busy input, which signals that a higher-priority internal requester owns the memory. While an access waits, the data buffer is already enabled. No address phase starts until both conditions clear. An access that follows right after another one therefore sees an acknowledge delay of tens of cycles, not a handful.

The acknowledge stays asserted until chip-select is seen released. A new access is accepted only after both strobes have been seen inactive.

Top module: `hostAccessSeq`

## Requirements
- R1: While reset is asserted, the outputs are held as follows:
  - hostAckN, addrBufEnN and dataBufEnN are high.
  - latchClk is high.
  - dataDirOut, memStb, holdoffActive and regSel are low.
  - regAddr is zero.
- R2: The strobes pass through a two-flop synchronizer. Take an idle block with no holdoff and no busy, where chip-select and a strobe fall between clock edges. addrBufEnN then falls after the third rising edge, and hostAckN falls after the sixth rising edge.
- R3: dataBufEnN is low from the edge that accepts an access until the access ends. During that time, dataDirOut is 1 for a read and 0 for a write. If both strobes are active, the access is a read.
- R4: addrBufEnN is low for exactly one cycle. latchClk is low in that cycle and the two cycles after it. latchClk returns high in the same cycle that hostAckN falls.
- R5: memStb is a single-cycle pulse. It occurs two cycles after the address-buffer enable cycle.
- R6: In the address-enable cycle, the block samples hostAddr bit 16 into regSel (1 = command register, 0 = RAM). It also loads regAddr:
  - with hostAddr[15:0] for a RAM access, or when testAccess is 1;
  - with zero for a command-register access when testAccess is 0.
- R7: Once asserted, hostAckN stays low until chip-select is sampled high. It rises after the third rising edge following the release of chip-select.
- R8: When an access ends, a holdoff counter is loaded with HOLDOFF_CYC (default 23). holdoffActive is high while the counter is nonzero, and no address phase begins while it is high. With the default, an access started as soon as the previous acknowledge rises sees its acknowledge 23 to 29 edges later.
- R9: While memBusy is high, an accepted access waits with dataBufEnN low. Its address phase starts on the edge after memBusy is seen low.
- R10: After an access is accepted, no new access starts until both the read and write strobes have been sampled high.
- R11: If chip-select is released while an access is still waiting, the block returns to idle. No acknowledge is given and the holdoff counter is not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | 1 | Host chip-select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostAddr | input | ADDR_W | Host address; the top bit selects the command register |
| testAccess | input | 1 | Test mode: lower address bits also used for command-register accesses |
| memBusy | input | 1 | Higher-priority internal requester owns the memory |
| hostAckN | output | 1 | Acknowledge to the host, active low |
| addrBufEnN | output | 1 | External address-buffer enable, active low |
| dataBufEnN | output | 1 | External data-buffer enable, active low |
| dataDirOut | output | 1 | Data-buffer direction, 1 = toward the host |
| latchClk | output | 1 | Data-latch clock, capture on rising edge |
| memStb | output | 1 | One-cycle internal data-phase strobe |
| regSel | output | 1 | Captured target: 1 = command register, 0 = RAM |
| regAddr | output | ADDR_W-1 | Captured lower address, masked for command-register accesses |
| holdoffActive | output | 1 | Holdoff window running |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Back-to-back accesses.** A new access starts the moment the previous acknowledge rises. A design that skips or shortens the holdoff returns a six-cycle acknowledge instead of one in the mid-twenties.
- **Busy grant during a wait.** memBusy is held high while an access waits. A design that ignores the grant opens the address buffer early. A design that forgets the request never acknowledges.
- **Read strobe held low across chip-select cycles.** This checks re-arming. A design that re-arms on chip-select alone would run a second access.
- **Release of chip-select during a wait.** A design that loads the holdoff here, or that finishes the access anyway, shows a spurious holdoff or acknowledge.
- **Address masking.** Command-register accesses are run with the test mode both set and cleared, to check how the lower address bits are masked.

// File: rtl/hostSeqPkg.sv
package hostSeqPkg;

  // Sequencer phases, in the order an access walks through them.
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PEND,
    SEQ_ADDR,
    SEQ_HOLD,
    SEQ_DRIVE,
    SEQ_LATCH,
    SEQ_ACK
  } seqStateE;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic captureAddr;
    logic loadHoldoff;
  } dpStrobeT;

  // Qualified (synchronized, active-high) status back to the control.
  typedef struct packed {
    logic csAct;
    logic rdAct;
    logic wrAct;
    logic holdoff;
  } dpStatusT;

endpackage

// File: rtl/hostSeqDatapath.sv
module hostSeqDatapath
  import hostSeqPkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int HOLDOFF_CYC = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              testAccess,
  input  dpStrobeT          stb,
  output dpStatusT          status,
  output logic              regSel,
  output logic [ADDR_W-2:0] regAddr,
  output logic              holdoffActive
);

  localparam int LOW_W   = ADDR_W - 1;
  localparam int SEL_BIT = ADDR_W - 1;
  localparam int RAW_CW  = $clog2(HOLDOFF_CYC + 1);
  localparam int CNT_W   = (RAW_CW < 1) ? 1 : RAW_CW;

  // Strobe synchronizer: one 3-bit word {cs, rd, wr} per stage, active high.
  logic [SYNC_STAGES-1:0][2:0] syncChain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
    end else begin
      syncChain[0] <= {~hostCsN, ~hostRdN, ~hostWrN};
      for (int s = 1; s < SYNC_STAGES; s++) begin
        syncChain[s] <= syncChain[s-1];
      end
    end
  end

  assign status.csAct   = syncChain[SYNC_STAGES-1][2];
  assign status.rdAct   = syncChain[SYNC_STAGES-1][1];
  assign status.wrAct   = syncChain[SYNC_STAGES-1][0];
  assign status.holdoff = holdoffActive;

  // Target decode and lower-address capture during the address-enable cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regSel  <= 1'b0;
      regAddr <= '0;
    end else if (stb.captureAddr) begin
      regSel  <= hostAddr[SEL_BIT];
      regAddr <= (testAccess || !hostAddr[SEL_BIT]) ? hostAddr[LOW_W-1:0] : '0;
    end
  end

  // Holdoff window after each completed host access.
  generate
    if (HOLDOFF_CYC > 0) begin : genHoldoff
      logic [CNT_W-1:0] holdCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdCnt <= '0;
        end else if (stb.loadHoldoff) begin
          holdCnt <= CNT_W'(HOLDOFF_CYC);
        end else if (holdCnt != '0) begin
          holdCnt <= holdCnt - 1'b1;
        end
      end

      assign holdoffActive = (holdCnt != '0);

      assert_hold_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
        holdCnt <= CNT_W'(HOLDOFF_CYC));

      assert_hold_opens_R8: assert property (@(posedge clk) disable iff (!rstN)
        stb.loadHoldoff |=> holdoffActive);
    end else begin : genNoHoldoff
      assign holdoffActive = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/hostSeqControl.sv
module hostSeqControl
  import hostSeqPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpStatusT status,
  input  logic     memBusy,
  output dpStrobeT stb,
  output logic     hostAckN,
  output logic     addrBufEnN,
  output logic     dataBufEnN,
  output logic     dataDirOut,
  output logic     latchClk,
  output logic     memStb
);

  seqStateE state, nextState;
  logic     isRead;
  logic     armed;
  logic     reqSeen;
  logic     mayStart;
  logic     accept;

  assign reqSeen  = status.csAct && (status.rdAct || status.wrAct) && armed;
  assign mayStart = !status.holdoff && !memBusy;
  assign accept   = (state == SEQ_IDLE) && reqSeen;

  always_comb begin
    nextState = state;
    unique case (state)
      SEQ_IDLE:  if (reqSeen) nextState = mayStart ? SEQ_ADDR : SEQ_PEND;
      SEQ_PEND: begin
        if (!status.csAct)  nextState = SEQ_IDLE;
        else if (mayStart)  nextState = SEQ_ADDR;
      end
      SEQ_ADDR:  nextState = SEQ_HOLD;
      SEQ_HOLD:  nextState = SEQ_DRIVE;
      SEQ_DRIVE: nextState = SEQ_LATCH;
      SEQ_LATCH: nextState = SEQ_ACK;
      SEQ_ACK:   if (!status.csAct) nextState = SEQ_IDLE;
      default:   nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= SEQ_IDLE;
      isRead <= 1'b0;
      armed  <= 1'b1;
    end else begin
      state <= nextState;
      if (accept) begin
        isRead <= status.rdAct;
      end
      if (accept) begin
        armed <= 1'b0;
      end else if (!status.rdAct && !status.wrAct) begin
        armed <= 1'b1;
      end
    end
  end

  // Strobes to the datapath.
  assign stb.captureAddr = (state == SEQ_ADDR);
  assign stb.loadHoldoff = (state == SEQ_ACK) && !status.csAct;

  // Pin choreography decoded from the phase.
  assign addrBufEnN = (state != SEQ_ADDR);
  assign dataBufEnN = (state == SEQ_IDLE);
  assign dataDirOut = (state != SEQ_IDLE) && isRead;
  assign latchClk   = !((state == SEQ_ADDR) || (state == SEQ_HOLD) || (state == SEQ_DRIVE));
  assign memStb     = (state == SEQ_DRIVE);
  assign hostAckN   = !((state == SEQ_LATCH) || (state == SEQ_ACK));

  assert_addr_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    !addrBufEnN |=> addrBufEnN);

  assert_addr_in_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    !addrBufEnN |-> !dataBufEnN);

  assert_stb_after_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    memStb |-> $past(!addrBufEnN, 2));

  assert_start_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrBufEnN) |-> !$past(status.holdoff));

  assert_start_granted_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrBufEnN) |-> !$past(memBusy));

  assert_ack_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!hostAckN && status.csAct) |=> !hostAckN);

  assert_latch_with_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchClk) |-> !hostAckN);

endmodule

// File: rtl/hostAccessSeq.sv
module hostAccessSeq
  import hostSeqPkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int HOLDOFF_CYC = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              testAccess,
  input  logic              memBusy,
  output logic              hostAckN,
  output logic              addrBufEnN,
  output logic              dataBufEnN,
  output logic              dataDirOut,
  output logic              latchClk,
  output logic              memStb,
  output logic              regSel,
  output logic [ADDR_W-2:0] regAddr,
  output logic              holdoffActive
);

  dpStrobeT dpStb;
  dpStatusT dpStatus;

  hostSeqDatapath #(
    .ADDR_W      (ADDR_W),
    .HOLDOFF_CYC (HOLDOFF_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDatapath (
    .clk           (clk),
    .rstN          (rstN),
    .hostCsN       (hostCsN),
    .hostRdN       (hostRdN),
    .hostWrN       (hostWrN),
    .hostAddr      (hostAddr),
    .testAccess    (testAccess),
    .stb           (dpStb),
    .status        (dpStatus),
    .regSel        (regSel),
    .regAddr       (regAddr),
    .holdoffActive (holdoffActive)
  );

  hostSeqControl uControl (
    .clk        (clk),
    .rstN       (rstN),
    .status     (dpStatus),
    .memBusy    (memBusy),
    .stb        (dpStb),
    .hostAckN   (hostAckN),
    .addrBufEnN (addrBufEnN),
    .dataBufEnN (dataBufEnN),
    .dataDirOut (dataDirOut),
    .latchClk   (latchClk),
    .memStb     (memStb)
  );

endmodule

// File: tb/hostAccessSeq_test.sv
`timescale 1ns/1ps
module hostAccessSeq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostCsN = 1'b1;
  logic        hostRdN = 1'b1;
  logic        hostWrN = 1'b1;
  logic [16:0] hostAddr = '0;
  logic        testAccess = 1'b0;
  logic        memBusy = 1'b0;
  logic        hostAckN, addrBufEnN, dataBufEnN, dataDirOut, latchClk, memStb;
  logic        regSel, holdoffActive;
  logic [15:0] regAddr;

  int checks = 0;
  int errors = 0;
  bit modelOn = 0;

  always #10 clk = ~clk;

  hostAccessSeq uut (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostAddr(hostAddr), .testAccess(testAccess), .memBusy(memBusy),
    .hostAckN(hostAckN), .addrBufEnN(addrBufEnN), .dataBufEnN(dataBufEnN),
    .dataDirOut(dataDirOut), .latchClk(latchClk), .memStb(memStb),
    .regSel(regSel), .regAddr(regAddr), .holdoffActive(holdoffActive)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase number 0 idle, 1 waiting, 2 address, 3 hold,
  // 4 data, 5 latch, 6 acknowledged.
  int          mPhase;
  int          mHold;
  bit          mRead, mArmed, mSel;
  logic [15:0] mAddr;
  bit [2:0]    mSyncA, mSyncB;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mHold = 0; mRead = 0; mArmed = 1; mSel = 0; mAddr = 0;
      mSyncA = 0; mSyncB = 0;
    end else begin
      automatic bit cs = mSyncB[2];
      automatic bit rd = mSyncB[1];
      automatic bit wr = mSyncB[0];
      automatic bit req = cs && (rd || wr) && mArmed;
      automatic bit go = (mHold == 0) && !memBusy;
      automatic int nPh = mPhase;
      automatic bit acc = (mPhase == 0) && req;
      case (mPhase)
        0: if (req) nPh = go ? 2 : 1;
        1: if (!cs) nPh = 0; else if (go) nPh = 2;
        6: if (!cs) nPh = 0;
        default: nPh = mPhase + 1;
      endcase
      if (mPhase == 2) begin
        mSel = hostAddr[16];
        mAddr = (testAccess || !hostAddr[16]) ? hostAddr[15:0] : 16'h0;
      end
      if (mPhase == 6 && !cs) mHold = 23;
      else if (mHold > 0) mHold = mHold - 1;
      if (acc) mRead = rd;
      if (acc) mArmed = 0; else if (!rd && !wr) mArmed = 1;
      mPhase = nPh;
      mSyncB = mSyncA;
      mSyncA = {~hostCsN, ~hostRdN, ~hostWrN};
    end
  end

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check(hostAckN,   !(mPhase == 5 || mPhase == 6), "R2 R7 hostAckN");
      check(addrBufEnN, !(mPhase == 2), "R4 addrBufEnN");
      check(dataBufEnN, (mPhase == 0), "R3 R9 dataBufEnN");
      check(dataDirOut, (mPhase != 0) && mRead, "R3 dataDirOut");
      check(latchClk,   !(mPhase >= 2 && mPhase <= 4), "R4 latchClk");
      check(memStb,     (mPhase == 4), "R5 memStb");
      check(holdoffActive, (mHold != 0), "R8 R11 holdoffActive");
      check(regSel,     mSel, "R6 regSel");
      check(regAddr,    mAddr, "R6 regAddr");
    end
  end

  // Starts an access and returns the number of negedges until the ack is seen low.
  task automatic startAccess(input bit rd, input logic [16:0] a, input bit tst, output int lat);
    hostAddr = a; testAccess = tst; hostCsN = 0;
    if (rd) hostRdN = 0; else hostWrN = 0;
    lat = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); lat++;
      if (!hostAckN) break;
    end
  endtask

  task automatic releaseAll();
    hostCsN = 1; hostRdN = 1; hostWrN = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hostAckN) break;
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int lat;
    bit ackSeen;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(hostAckN, 1, "R1 hostAckN");
    check(addrBufEnN, 1, "R1 addrBufEnN");
    check(dataBufEnN, 1, "R1 dataBufEnN");
    check(latchClk, 1, "R1 latchClk");
    check({dataDirOut, memStb, holdoffActive, regSel}, 0, "R1 low outputs");
    check(regAddr, 0, "R1 regAddr");
    rstN = 1; modelOn = 1;
    repeat (2) @(negedge clk);

    // Command-register read from idle, test mode off
    startAccess(1, 17'h1_2345, 0, lat);
    check(lat, 6, "R2 idle ack latency");
    check(regSel, 1, "R6 command select");
    check(regAddr, 0, "R6 masked address");
    releaseAll();

    // Back-to-back RAM write
    startAccess(0, 17'h0_ABCD, 0, lat);
    check((lat >= 23 && lat <= 29), 1, "R8 back-to-back latency");
    check(regSel, 0, "R6 RAM select");
    check(regAddr, 16'hABCD, "R6 RAM address");
    releaseAll();
    repeat (30) @(negedge clk);

    // Command read with test access
    startAccess(1, 17'h1_5A5A, 1, lat);
    check(regAddr, 16'h5A5A, "R6 test access address");
    releaseAll();
    repeat (30) @(negedge clk);

    // Busy grant defers the access
    memBusy = 1;
    fork
      startAccess(1, 17'h0_0100, 0, lat);
      begin repeat (10) @(negedge clk); memBusy = 0; end
    join
    check(lat, 14, "R9 busy-deferred latency");
    releaseAll();
    repeat (30) @(negedge clk);

    // Re-arm: read strobe held low across a chip-select cycle
    startAccess(1, 17'h0_0200, 0, lat);
    hostCsN = 1;
    repeat (30) @(negedge clk);
    hostCsN = 0;
    ackSeen = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (!hostAckN) ackSeen = 1;
    end
    check(ackSeen, 0, "R10 no access without re-arm");
    hostRdN = 1;
    repeat (4) @(negedge clk);
    hostRdN = 0;
    ackSeen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!hostAckN) ackSeen = 1;
    end
    check(ackSeen, 1, "R10 access after re-arm");
    releaseAll();
    repeat (30) @(negedge clk);

    // Abort while waiting
    memBusy = 1;
    hostCsN = 0; hostWrN = 0;
    repeat (6) @(negedge clk);
    check(dataBufEnN, 0, "R11 waiting access holds data buffer");
    hostCsN = 1; hostWrN = 1;
    ackSeen = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!hostAckN) ackSeen = 1;
    end
    check(ackSeen, 0, "R11 no acknowledge after abort");
    check(dataBufEnN, 1, "R11 idle after abort");
    check(holdoffActive, 0, "R11 no holdoff after abort");
    memBusy = 0;
    repeat (5) @(negedge clk);

    finishRun();
  end

endmodule